// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block runs the hardware boot sequence of a small microcontroller-class core whose boot area holds data, not code. When reset is released, it reads two 32-bit table words through a 16-bit instruction-memory read port. The first word becomes the initial stack pointer. The second word is the address of the reset handler.

The handler word must have its low bit set, which marks a valid entry. The sequencer then clears that bit and hands the result to the fetch stage as the first program counter, with a one-cycle start pulse. If the low bit is clear, it raises a fault and never starts execution. A strap input chooses where the table sits: at address zero, or at a high alternate base. The status register comes out of reset holding a fixed value. Executing instructions is left to the stages that follow.

Top module: `boot_vector_loader`

## Requirements
- R1: While reset is held, `rd_req`, `start` and `fault` are low, `sp_out` and `pc_out` are zero, and `status_out` equals 0x0000_00E0.
- R2: With `alt_base_sel` low, the table is read from base 0x0000_0000, so the first read address is 0x0000_0000.
- R3: `alt_base_sel` is sampled on the first clock edge after reset is released, and later changes have no effect. When sampled high, the base is 0xFFFF_0000.
- R4: Exactly four halfword reads are issued, at base+0, base+2, base+4 and base+6 in that order. Each read holds `rd_req` high and `rd_addr` stable until `rd_valid` is seen, and a read completes on a clock edge where both are high.
- R5: `sp_out` becomes {halfword at base+2, halfword at base+0}, so the lower address supplies bits 15:0.
- R6: If bit 0 of the handler word {base+6, base+4} is 1, `pc_out` becomes that word with bit 0 cleared. `start` is then high for exactly one cycle, in the cycle after the fourth read completes.
- R7: If bit 0 of the handler word is 0, `fault` rises in the cycle after the fourth read completes and stays high until reset. `start` is never asserted and `pc_out` stays zero.
- R8: After the start pulse, no further reads are issued, `start` stays low, and `pc_out` and `sp_out` hold until the next reset.
- R9: `status_out` keeps the value 0x0000_00E0 for the whole time between resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_base_sel | input | 1 | Strap: 1 selects the alternate table base |
| rd_req | output | 1 | Halfword read request |
| rd_addr | output | 32 | Byte address of the halfword being read |
| rd_data | input | 16 | Returned halfword |
| rd_valid | input | 1 | Read data is valid this cycle |
| sp_out | output | 32 | Initial stack pointer |
| pc_out | output | 32 | First fetch address |
| status_out | output | 32 | Status register |
| start | output | 1 | One-cycle pulse: fetch may begin at `pc_out` |
| fault | output | 1 | Invalid handler entry; held until reset |

## Verification
The bench builds the block with its default parameters: a 0xFFFF_0000 alternate base and a 0xE0 status value. With these values, both table locations and the full 32-bit address arithmetic are within reach.

A memory model answers each read after 0 to 3 wait cycles. This exercises both back-to-back completions and held requests. Handler words are chosen to cover:
- a set low bit next to high-order ones,
- a word of only 1,
- cleared low bits with every other bit set.

Strap changes are made right after the sampling edge, to show that they are ignored.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int WORD_W    = 32;
  localparam int HALF_W    = 16;
  localparam int NUM_READS = 4;
  localparam int IDX_W     = $clog2(NUM_READS);

  typedef enum logic [2:0] {
    ST_STRAP,
    ST_READ,
    ST_GO,
    ST_IDLE,
    ST_FAULT
  } seq_state_t;

  // byte address of halfword number idx above base
  function automatic logic [WORD_W-1:0] read_addr(input logic [WORD_W-1:0] base,
                                                  input logic [IDX_W-1:0]  idx);
    return base + WORD_W'({idx, 1'b0});
  endfunction

  // lower address supplies the low half
  function automatic logic [WORD_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                    input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic entry_valid(input logic [WORD_W-1:0] w);
    return w[0];
  endfunction

  function automatic logic [WORD_W-1:0] entry_pc(input logic [WORD_W-1:0] w);
    return {w[WORD_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/vseq_addr_gen.sv
module vseq_addr_gen
  import vseq_pkg::*;
#(
  parameter logic [WORD_W-1:0] ALT_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              strap,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] addr
);
  logic [WORD_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (capture) base_q <= strap ? ALT_BASE : '0;
  end

  assign addr = read_addr(base_q, idx);

  // R3
  base_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(base_q));
endmodule

// File: rtl/vseq_word_pack.sv
module vseq_word_pack
  import vseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [IDX_W-1:0]  idx,
  input  logic [HALF_W-1:0] rd_data,
  output logic [WORD_W-1:0] word_now,
  output logic [WORD_W-1:0] sp_q
);
  logic [HALF_W-1:0] lo_q;
  logic              sp_load;

  assign word_now = join_halves(rd_data, lo_q);
  assign sp_load  = accept && (idx == IDX_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      sp_q <= '0;
    end else begin
      if (accept && !idx[0]) lo_q <= rd_data;
      if (sp_load) sp_q <= word_now;
    end
  end

  // R5
  sp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |=> sp_q[HALF_W-1:0] == $past(lo_q) && sp_q[WORD_W-1:HALF_W] == $past(rd_data));
  // R8
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_load |=> $stable(sp_q));
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter logic [WORD_W-1:0] STATUS_INIT = 32'h0000_00E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] word_now,
  output logic              rd_req,
  output logic              capture,
  output logic              accept,
  output logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] pc_q,
  output logic [WORD_W-1:0] status_q,
  output logic              start,
  output logic              fault
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_READS - 1);

  seq_state_t state;
  logic       last_done;

  assign rd_req    = (state == ST_READ);
  assign capture   = (state == ST_STRAP);
  assign accept    = rd_req && rd_valid;
  assign last_done = accept && (idx == LAST);
  assign start     = (state == ST_GO);
  assign fault     = (state == ST_FAULT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_STRAP;
      idx      <= '0;
      pc_q     <= '0;
      status_q <= STATUS_INIT;
    end else begin
      case (state)
        ST_STRAP: begin
          state <= ST_READ;
          idx   <= '0;
        end
        ST_READ: begin
          if (accept) idx <= idx + IDX_W'(1);
          if (last_done) begin
            if (entry_valid(word_now)) begin
              pc_q  <= entry_pc(word_now);
              state <= ST_GO;
            end else begin
              state <= ST_FAULT;
            end
          end
        end
        ST_GO:   state <= ST_IDLE;
        default: state <= state;
      endcase
    end
  end

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  // R6
  pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> pc_q[0] == 1'b0);
  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault && !start && pc_q == '0);
  // R8
  quiet_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !rd_req && $stable(pc_q));
  // R9
  status_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(status_q));
endmodule

// File: rtl/boot_vector_loader.sv
module boot_vector_loader
  import vseq_pkg::*;
#(
  parameter logic [31:0] ALT_BASE    = 32'hFFFF_0000,
  parameter logic [31:0] STATUS_INIT = 32'h0000_00E0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alt_base_sel,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic [15:0] rd_data,
  input  logic        rd_valid,
  output logic [31:0] sp_out,
  output logic [31:0] pc_out,
  output logic [31:0] status_out,
  output logic        start,
  output logic        fault
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_READS - 1);

  logic              capture;
  logic              accept;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] word_now;

  vseq_ctrl #(.STATUS_INIT(STATUS_INIT)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .word_now (word_now),
    .rd_req   (rd_req),
    .capture  (capture),
    .accept   (accept),
    .idx      (rd_idx),
    .pc_q     (pc_out),
    .status_q (status_out),
    .start    (start),
    .fault    (fault)
  );

  vseq_addr_gen #(.ALT_BASE(ALT_BASE)) addr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .strap   (alt_base_sel),
    .idx     (rd_idx),
    .addr    (rd_addr)
  );

  vseq_word_pack pack_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .idx      (rd_idx),
    .rd_data  (rd_data),
    .word_now (word_now),
    .sp_q     (sp_out)
  );

  // R4
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));
  // R4
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_valid && rd_idx != LAST_IDX |=> rd_req && rd_addr == $past(rd_addr) + 32'd2);
  // R7
  no_start_and_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && fault));
endmodule

// File: tb/boot_vector_loader_tb_top.sv
module boot_vector_loader_tb_top;
  localparam logic [31:0] ALT = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_base_sel = 1'b0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic [15:0] rd_data = '0;
  logic        rd_valid = 1'b0;
  logic [31:0] sp_out, pc_out, status_out;
  logic        start, fault;

  boot_vector_loader dut_i (
    .clk(clk), .rst_n(rst_n), .alt_base_sel(alt_base_sel),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .sp_out(sp_out), .pc_out(pc_out), .status_out(status_out),
    .start(start), .fault(fault)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, accept_cyc = 0, lat = 0, wcnt = 0;
  logic [31:0] cur_sp, cur_hv, cur_base;
  logic [31:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_hw(input logic [31:0] a);
    logic [31:0] off = a - cur_base;
    case (off)
      32'd0: return cur_sp[15:0];
      32'd2: return cur_sp[31:16];
      32'd4: return cur_hv[15:0];
      32'd6: return cur_hv[31:16];
      default: return 16'hBEEF;
    endcase
  endfunction

  // memory responder with programmable wait cycles
  initial forever begin
    @(posedge clk); #2;
    if (!rst_n || !rd_req) begin
      rd_valid = 1'b0; wcnt = 0;
    end else if (wcnt >= lat) begin
      rd_valid = 1'b1; rd_data = mem_hw(rd_addr); wcnt = 0;
    end else begin
      rd_valid = 1'b0; wcnt++;
    end
  end

  // monitor: pops expected read addresses as reads complete
  initial forever begin
    @(negedge clk);
    cyc++;
    if (rst_n && rd_req && rd_valid) begin
      accept_cyc = cyc;
      if (exp_q.size() == 0) chk(1'b0, "R4/R8", "unexpected read", rd_addr, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rd_addr == e, "R2/R3/R4", "read address", rd_addr, e);
      end
    end
  end

  // watchdog
  initial forever begin
    @(negedge clk);
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_case(input bit strap_v, input bit flip, input logic [31:0] sp,
                          input logic [31:0] hv, input int lat_v, input bit exp_fault);
    bit seen = 0;
    int ev = 0;
    logic [31:0] exp_pc = {hv[31:1], 1'b0};
    rst_n = 1'b0;
    alt_base_sel = strap_v;
    cur_sp = sp; cur_hv = hv; lat = lat_v;
    cur_base = strap_v ? ALT : 32'h0;
    exp_q.delete();
    for (int i = 0; i < 4; i++) exp_q.push_back(cur_base + 32'(2 * i));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rd_req && !start && !fault, "R1", "req/start/fault in reset",
        {29'b0, rd_req, start, fault}, 32'h0);
    chk(sp_out == 0 && pc_out == 0, "R1", "sp/pc in reset", sp_out | pc_out, 32'h0);
    chk(status_out == 32'hE0, "R1", "status in reset", status_out, 32'hE0);
    rst_n = 1'b1;
    if (flip) begin
      @(posedge clk); #1;
      alt_base_sel = ~strap_v; // R3 change after sampling edge is ignored
    end
    for (int k = 0; k < 200 && !seen; k++) begin
      @(negedge clk); #1;
      if (start || fault) begin seen = 1; ev = cyc; end
    end
    chk(exp_q.size() == 0, "R4", "reads left outstanding", exp_q.size(), 0);
    chk(ev == accept_cyc + 1, exp_fault ? "R7" : "R6", "event cycle", ev, accept_cyc + 1);
    chk(sp_out == sp, "R5", "stack pointer", sp_out, sp);
    if (exp_fault) begin
      chk(fault && !start, "R7", "fault without start", {30'b0, fault, start}, 32'h2);
      chk(pc_out == 0, "R7", "pc after fault", pc_out, 32'h0);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk); #1;
        chk(fault && !start && !rd_req, "R7", "fault held", {29'b0, fault, start, rd_req}, 32'h4);
      end
    end else begin
      chk(start && !fault, "R6", "start pulse", {30'b0, start, fault}, 32'h2);
      chk(pc_out == exp_pc, "R6", "entry pc", pc_out, exp_pc);
      @(negedge clk); #1;
      chk(!start, "R6", "start width", start, 32'h0);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk); #1;
        chk(!start && !rd_req && pc_out == exp_pc && sp_out == sp, "R8", "idle after start",
            pc_out, exp_pc);
      end
    end
    chk(status_out == 32'hE0, "R9", "status held", status_out, 32'hE0);
  endtask

  initial begin
    run_case(1'b0, 1'b0, 32'h2000_1000, 32'h0000_0101, 0, 1'b0);
    run_case(1'b1, 1'b0, 32'h1234_5678, 32'hFFFF_0043, 2, 1'b0);
    run_case(1'b0, 1'b0, 32'h2000_0400, 32'h0000_0100, 1, 1'b1);
    run_case(1'b1, 1'b1, 32'hA5A5_5A5A, 32'hABCD_0001, 3, 1'b0);
    run_case(1'b0, 1'b1, 32'h0000_0000, 32'hFFFF_FFFE, 0, 1'b1);
    run_case(1'b0, 1'b0, 32'hFFFF_FFFC, 32'h0000_0001, 1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule